// File: doc/BRIEF.md
# Four-way split large integer multiplier

This block multiplies two 256-bit unsigned integers and returns the full 512-bit product. Each operand is cut into four 64-bit limbs and treated as a cubic polynomial in 2^64. Both polynomials are evaluated at seven points: 0, 1, -1, 2, -2, 3 and infinity. The seven pointwise products give the seven coefficients of the product polynomial through exact interpolation. The coefficients are then added back together at their limb offsets.

A single signed multiplier forms the seven pointwise products one per cycle. A single scaled add/subtract unit, followed by a constant divider, then runs a fixed list of twenty interpolation steps. These steps share one eight-entry register file. Every division in the interpolation is exact. Division by 2, 4 and 8 is an arithmetic shift. Division by 3 and by 5 is a multiplication by the modular inverse of the divisor, so it finishes in one step and carries no remainder chain.

A caller raises `start` for one cycle with the operands present, waits for the `done` pulse, and then reads `product`.

Top module: `tc4_mult`

## Requirements
- R1: When a run completes, `product` equals the unsigned product of the `op_a` and `op_b` values sampled with the accepted start. This holds for every 256-bit operand pair, including zero, one and all-ones operands, and operands whose 64-bit limbs are each all zeros or all ones.
- R2: While idle, a `start` high at a rising edge latches both operands and starts a run, and `busy` is high from that edge on.
- R3: `done` rises exactly 28 rising edges after the edge that accepted `start`. This is 7 product steps, 20 interpolation steps and 1 recombination step.
- R4: `done` is high for exactly one cycle per run, and `busy` is low whenever `done` is high.
- R5: While `busy` is high, `start` is ignored, and so are changes on `op_a` and `op_b`. The running operation keeps its timing and its result.
- R6: `product` changes only in the cycle where `done` is high, and otherwise holds the last result.
- R7: While `rst_n` is low, `busy` and `done` are 0 and `product` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| op_a | input | 256 | Multiplicand, sampled with accepted start |
| op_b | input | 256 | Multiplier, sampled with accepted start |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: product is valid |
| product | output | 512 | Full unsigned product |

## Verification
Operand pairs with all-zero, one and all-ones values test the extremes of the evaluation sums and the largest interpolation intermediates. A sweep where every 64-bit limb of each operand is either all zeros or all ones gives 256 pairs. Each such pair leaves different subsets of the seven coefficients at zero or at their maximum, so a fault in any single interpolation step or any recombination offset shows up as a wrong product. Random full-width operands test the carries between limbs. On some runs the bench raises `start` and flips the operands mid-run, and then checks that the result still matches the original pair.

// File: rtl/tc4_pkg.sv
package tc4_pkg;

  localparam int NPTS   = 7;
  localparam int NSTEPS = 20;
  localparam int LAT    = NPTS + NSTEPS + 1;

  typedef enum logic [2:0] {DV1, DV2, DV4, DV8, DV3, DV5} dv_e;

  typedef struct packed {
    logic [2:0] ra;
    logic [2:0] rb;
    logic       sub;
    logic [9:0] k;
    dv_e        dv;
    logic [2:0] rd;
  } uop_t;

  typedef struct packed {
    logic       inf;
    logic [7:0] k1;
    logic [7:0] k2;
    logic [7:0] k3;
  } pt_t;

  // Evaluation point p -> signed multipliers for limbs 1..3 (limb 0 has weight 1).
  function automatic pt_t point_coef(input logic [2:0] p);
    case (p)
      3'd0:    return '{1'b0, 8'd0,   8'd0, 8'd0};
      3'd1:    return '{1'b0, 8'd1,   8'd1, 8'd1};
      3'd2:    return '{1'b0, 8'hFF,  8'd1, 8'hFF};
      3'd3:    return '{1'b0, 8'd2,   8'd4, 8'd8};
      3'd4:    return '{1'b0, 8'hFE,  8'd4, 8'hF8};
      3'd5:    return '{1'b0, 8'd3,   8'd9, 8'd27};
      default: return '{1'b1, 8'd0,   8'd0, 8'd0};
    endcase
  endfunction

  function automatic uop_t mk(input logic [2:0] ra, input logic [2:0] rb,
                              input logic sub, input logic [9:0] k,
                              input dv_e dv, input logic [2:0] rd);
    return '{ra, rb, sub, k, dv, rd};
  endfunction

  // Interpolation schedule. Entry registers: 0:f(0) 1:f(1) 2:f(-1) 3:f(2)
  // 4:f(-2) 5:f(3) 6:f(inf) 7:scratch. Exit: c0..c6 in 0,1,7,4,2,5,6.
  function automatic uop_t schedule(input logic [4:0] s);
    case (s)
      5'd0:    return mk(3'd1, 3'd2, 1'b0, 10'd1,   DV2, 3'd7); // even sum at +-1
      5'd1:    return mk(3'd1, 3'd2, 1'b1, 10'd1,   DV2, 3'd1); // odd sum at +-1
      5'd2:    return mk(3'd3, 3'd4, 1'b0, 10'd1,   DV2, 3'd2); // even sum at +-2
      5'd3:    return mk(3'd3, 3'd4, 1'b1, 10'd1,   DV4, 3'd3); // odd sum at +-2
      5'd4:    return mk(3'd7, 3'd0, 1'b1, 10'd1,   DV1, 3'd7);
      5'd5:    return mk(3'd7, 3'd6, 1'b1, 10'd1,   DV1, 3'd7); // c2+c4
      5'd6:    return mk(3'd2, 3'd0, 1'b1, 10'd1,   DV1, 3'd2);
      5'd7:    return mk(3'd2, 3'd6, 1'b1, 10'd64,  DV4, 3'd2); // c2+4c4
      5'd8:    return mk(3'd2, 3'd7, 1'b1, 10'd1,   DV3, 3'd2); // c4
      5'd9:    return mk(3'd7, 3'd2, 1'b1, 10'd1,   DV1, 3'd7); // c2
      5'd10:   return mk(3'd5, 3'd0, 1'b1, 10'd1,   DV1, 3'd5);
      5'd11:   return mk(3'd5, 3'd7, 1'b1, 10'd9,   DV1, 3'd5);
      5'd12:   return mk(3'd5, 3'd2, 1'b1, 10'd81,  DV1, 3'd5);
      5'd13:   return mk(3'd5, 3'd6, 1'b1, 10'd729, DV3, 3'd5); // c1+9c3+81c5
      5'd14:   return mk(3'd3, 3'd1, 1'b1, 10'd1,   DV3, 3'd4); // c3+5c5
      5'd15:   return mk(3'd5, 3'd1, 1'b1, 10'd1,   DV8, 3'd5); // c3+10c5
      5'd16:   return mk(3'd5, 3'd4, 1'b1, 10'd1,   DV5, 3'd5); // c5
      5'd17:   return mk(3'd4, 3'd5, 1'b1, 10'd5,   DV1, 3'd4); // c3
      5'd18:   return mk(3'd1, 3'd4, 1'b1, 10'd1,   DV1, 3'd1);
      default: return mk(3'd1, 3'd5, 1'b1, 10'd1,   DV1, 3'd1); // c1
    endcase
  endfunction

endpackage

// File: rtl/tc4_eval.sv
module tc4_eval #(
  parameter int LW = 64,
  parameter int EW = LW + 8
) (
  input  logic [4*LW-1:0] limbs,
  input  logic [2:0]      pt,
  output logic [EW-1:0]   val
);
  import tc4_pkg::*;

  pt_t                cf;
  logic [EW-1:0]      l0, l1, l2, l3;
  logic [EW-1:0]      m1, m2, m3;

  assign cf = point_coef(pt);
  assign l0 = EW'(limbs[0*LW +: LW]);
  assign l1 = EW'(limbs[1*LW +: LW]);
  assign l2 = EW'(limbs[2*LW +: LW]);
  assign l3 = EW'(limbs[3*LW +: LW]);
  assign m1 = {{(EW-8){cf.k1[7]}}, cf.k1};
  assign m2 = {{(EW-8){cf.k2[7]}}, cf.k2};
  assign m3 = {{(EW-8){cf.k3[7]}}, cf.k3};

  // Two's complement modulo 2^EW; true value fits in EW signed bits.
  assign val = cf.inf ? l3 : (l0 + m1 * l1 + m2 * l2 + m3 * l3);
endmodule

// File: rtl/tc4_alu.sv
module tc4_alu #(
  parameter int W = 144
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  input  logic           sub,
  input  logic [9:0]     k,
  input  tc4_pkg::dv_e   dv,
  output logic [W-1:0]   r
);
  import tc4_pkg::*;

  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] INV3 = (ONES / W'(3)) * W'(2) + W'(1);
  localparam logic [W-1:0] INV5 = (ONES / W'(5)) * W'(4) + W'(1);

  logic [W-1:0] ky, s;

  assign ky = y * W'(k);
  assign s  = sub ? (x - ky) : (x + ky);

  // Exact constant division: shifts for powers of two, inverse multiply otherwise.
  always_comb begin
    case (dv)
      DV2:     r = $signed(s) >>> 1;
      DV4:     r = $signed(s) >>> 2;
      DV8:     r = $signed(s) >>> 3;
      DV3:     r = s * INV3;
      DV5:     r = s * INV5;
      default: r = s;
    endcase
  end
endmodule

// File: rtl/tc4_recomb.sv
module tc4_recomb #(
  parameter int LW = 64,
  parameter int PW = 144
) (
  input  logic [7*PW-1:0] coefs,
  output logic [8*LW-1:0] sum
);
  localparam int RW = 8 * LW;

  always_comb begin
    sum = '0;
    for (int i = 0; i < 7; i++) begin
      sum = sum + ({{(RW-PW){coefs[i*PW+PW-1]}}, coefs[i*PW +: PW]} << (LW * i));
    end
  end
endmodule

// File: rtl/tc4_mult.sv
module tc4_mult #(
  parameter int LIMB_W = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [4*LIMB_W-1:0]   op_a,
  input  logic [4*LIMB_W-1:0]   op_b,
  output logic                  busy,
  output logic                  done,
  output logic [8*LIMB_W-1:0]   product
);
  import tc4_pkg::*;

  localparam int OP_W  = 4 * LIMB_W;
  localparam int RES_W = 8 * LIMB_W;
  localparam int EV_W  = LIMB_W + 8;
  localparam int PR_W  = 2 * EV_W;

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_INTERP, S_FINAL} st_e;

  st_e              st_q, st_d;
  logic [4:0]       cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             ld_ops, rf_we, prod_we;
  logic [2:0]       rf_wa;
  logic [PR_W-1:0]  rf_wd;
  logic [OP_W-1:0]  a_q, b_q;
  logic [RES_W-1:0] prod_q, prod_sum;
  logic [PR_W-1:0]  rf_q [8];
  logic [EV_W-1:0]  ev_a, ev_b;
  logic [PR_W-1:0]  mul_res, alu_res;
  uop_t             uop;

  assign uop = schedule(cnt_q);

  tc4_eval #(.LW(LIMB_W), .EW(EV_W)) u_eval_a (.limbs(a_q), .pt(cnt_q[2:0]), .val(ev_a));
  tc4_eval #(.LW(LIMB_W), .EW(EV_W)) u_eval_b (.limbs(b_q), .pt(cnt_q[2:0]), .val(ev_b));

  // Shared signed pointwise multiplier (modulo 2^PR_W).
  assign mul_res = {{EV_W{ev_a[EV_W-1]}}, ev_a} * {{EV_W{ev_b[EV_W-1]}}, ev_b};

  tc4_alu #(.W(PR_W)) u_alu (
    .x(rf_q[uop.ra]), .y(rf_q[uop.rb]), .sub(uop.sub),
    .k(uop.k), .dv(uop.dv), .r(alu_res)
  );

  tc4_recomb #(.LW(LIMB_W), .PW(PR_W)) u_recomb (
    .coefs({rf_q[6], rf_q[5], rf_q[2], rf_q[4], rf_q[7], rf_q[1], rf_q[0]}),
    .sum(prod_sum)
  );

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    ld_ops  = 1'b0;
    rf_we   = 1'b0;
    rf_wa   = cnt_q[2:0];
    rf_wd   = mul_res;
    prod_we = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          ld_ops = 1'b1;
          cnt_d  = '0;
          st_d   = S_EVAL;
        end
      end
      S_EVAL: begin
        rf_we = 1'b1;
        if (cnt_q == 5'(NPTS - 1)) begin
          cnt_d = '0;
          st_d  = S_INTERP;
        end else begin
          cnt_d = cnt_q + 5'd1;
        end
      end
      S_INTERP: begin
        rf_we = 1'b1;
        rf_wa = uop.rd;
        rf_wd = alu_res;
        if (cnt_q == 5'(NSTEPS - 1)) begin
          cnt_d = '0;
          st_d  = S_FINAL;
        end else begin
          cnt_d = cnt_q + 5'd1;
        end
      end
      default: begin
        prod_we = 1'b1;
        done_d  = 1'b1;
        st_d    = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
      prod_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      if (prod_we) prod_q <= prod_sum;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_ops) begin
      a_q <= op_a;
      b_q <= op_b;
    end
    if (rf_we) rf_q[rf_wa] <= rf_wd;
  end

  assign busy    = (st_q != S_IDLE);
  assign done    = done_q;
  assign product = prod_q;
endmodule

// File: rtl/tc4_mult_chk.sv
module tc4_mult_chk #(
  parameter int LIMB_W = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic [8*LIMB_W-1:0] product
);
  import tc4_pkg::*;

  logic [5:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lat_q <= '0;
    else if (start && !busy)   lat_q <= '0;
    else if (busy)             lat_q <= lat_q + 6'd1;
  end

  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r2_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == 6'(LAT)));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r6_product_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(product) |-> done);

  always_comb begin
    if (!rst_n) begin
      a_r7_reset_idle: assert (!busy && !done);
    end
  end
endmodule

bind tc4_mult tc4_mult_chk #(.LIMB_W(LIMB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .product(product)
);

// File: tb/sim_tc4_mult.sv
module sim_tc4_mult;
  localparam int LIMB_W = 64;
  localparam int OP_W   = 4 * LIMB_W;
  localparam int RES_W  = 8 * LIMB_W;
  localparam int LAT    = 28;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [OP_W-1:0]  op_a, op_b;
  logic             busy, done;
  logic [RES_W-1:0] product;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  tc4_mult #(.LIMB_W(LIMB_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .product(product)
  );

  task automatic check(input bit ok, input string req,
                       input logic [RES_W-1:0] act, input logic [RES_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b, input bit disturb);
    logic [RES_W-1:0] exp;
    int seen;
    exp  = RES_W'(a) * RES_W'(b);
    seen = -1;
    @(negedge clk);
    start = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    for (int k = 0; k <= LAT + 2; k++) begin
      if (k == 0) check(busy === 1'b1, "R2 busy", RES_W'(busy), RES_W'(1));
      if (disturb && k >= 3 && k <= 5) begin
        start = 1'b1; op_a = ~a; op_b = ~b;
      end else begin
        start = 1'b0;
      end
      if (done === 1'b1 && seen < 0) seen = k;
      if (k == LAT) check(product === exp, disturb ? "R5 result" : "R1 product", product, exp);
      if (k == LAT + 1) check(done === 1'b0, "R4 pulse", RES_W'(done), RES_W'(0));
      if (k == LAT + 2) check(product === exp, "R6 hold", product, exp);
      @(negedge clk);
    end
    check(seen == LAT, "R3 latency", RES_W'(seen), RES_W'(LAT));
    start = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R3 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [OP_W-1:0] ones, a, b;
    ones  = '1;
    rst_n = 1'b0; start = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R7 reset ctrl", RES_W'({busy, done}), '0);
    check(product === '0, "R7 reset product", product, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 corner operands
    run('0, '0, 1'b0);
    run('0, ones, 1'b0);
    run(OP_W'(1), OP_W'(1), 1'b0);
    run(OP_W'(1), ones, 1'b0);
    run(ones, OP_W'(1), 1'b0);
    run(ones, ones, 1'b0);
    run(ones, ones, 1'b1);

    // R1 limb sweep: every limb all zeros or all ones
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        a = '0; b = '0;
        for (int l = 0; l < 4; l++) begin
          if (i[l]) a[l*LIMB_W +: LIMB_W] = '1;
          if (j[l]) b[l*LIMB_W +: LIMB_W] = '1;
        end
        run(a, b, ((i + j) % 5) == 0);
      end
    end

    // R1 and R5 with random operands
    for (int t = 0; t < 100; t++) begin
      for (int w = 0; w < OP_W; w += 32) begin
        a[w +: 32] = $urandom();
        b[w +: 32] = $urandom();
      end
      run(a, b, t[0]);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule